// File: doc/BRIEF.md
# Boot-Overlay Address Decoder

This block classifies each access on a 24-bit byte-addressed processor bus and raises one chip select for the resource it reaches: boot ROM, main RAM, the 2 KiB page-map RAM, the 32 KiB frame-buffer RAM, one of eight expansion slots, or one of three 16-bit status registers. For each decoded select it also gives the offset inside the resource, with the mirroring of the small RAMs already applied. A combinational `handled` flag marks accesses that reach something. A registered `unhandled` flag is raised one cycle later for every access that reaches nothing, so a monitor can log it. The access is not faulted.

After reset a boot overlay is in force. While the overlay state bit `map_live` is low, address bit 23 is forced high before decoding. Every low address then lands in ROM, so the processor fetches its reset vectors and first instructions from there. Software releases the overlay by writing a one to the overlay control location in the upper I/O zone. The block also returns the read data for the three status registers, whose values arrive on input ports, and it places each value in the byte lanes that the access size calls for.

Top module: `boot_map_decoder`

## Requirements
- R1: After reset `map_live` is 0. While it is 0, address bit 23 is forced to 1 before decoding, so address 0x000100 selects ROM at offset 0x000100 and address 0x410000 selects expansion slot 0.
- R2: Effective addresses 0x800000 to 0xBFFFFF select ROM with offset = address bits 21:0. ROM is checked first. A write to ROM is reported as handled and changes no state.
- R3: When the ROM check fails, an effective address below RAM_BYTES (default 0x200000) selects main RAM with offset = address.
- R4: Addresses 0x400000 to 0x7FFFFF are subdecoded on bits 19:16: 0 = map RAM, 1 = general status, 2 = frame-buffer RAM, 3 = bus status 0, 4 = bus status 1. Values 5 to 15 select nothing. Addresses from RAM_BYTES to 0x3FFFFF also select nothing. At most one select is high at a time.
- R5: The map RAM offset is the address masked with 0x7FF, and the frame-buffer offset is the address masked with 0x7FFF. Each memory therefore mirrors through its 64 KiB slot.
- R6: A status register read returns the 16-bit value in both halves for long size (2). For word size (1) it returns the value in bits 15:0 with zeros above. For byte size (0) it returns the high byte at an even address and the low byte at an odd address, in bits 7:0.
- R7: Writes to the status registers and to ROM are handled, and they leave `map_live` unchanged.
- R8: The overlay control is at 0xE00000 to 0xFFFFFF, with bits 21 = 1, 18:16 = 4 and 14:12 = 3. A word or long write sets `map_live` from data bit 15. A byte write at an even address sets it from data bit 7. A byte write at an odd address is handled and changes nothing. A read of this location is not handled.
- R9: Addresses 0xC00000 to 0xDFFFFF raise expansion select bit number address[20:18], with offset = address bits 17:0, and are handled.
- R10: `unhandled` is high in the cycle after an access (`acc_valid` = 1) whose `handled` was 0. It is low after an idle cycle or after a handled access. Other zone-B locations with bit 21 = 1 are not handled.
- R11: Any access that is not a status read returns the lane mask as read data: 0xFFFFFFFF for long, 0x0000FFFF for word, 0x000000FF for byte.
- R12: While `acc_valid` is 0, all selects and `handled` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | Access strobe for the current cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 byte, 1 word, 2 long |
| acc_addr | input | 24 | Byte address |
| acc_wdata | input | 32 | Write data, right-aligned |
| gen_status | input | 16 | General status register value |
| bus_status0 | input | 16 | Bus status register 0 value |
| bus_status1 | input | 16 | Bus status register 1 value |
| sel_rom | output | 1 | ROM select |
| sel_ram | output | 1 | Main RAM select |
| sel_map | output | 1 | Map RAM select |
| sel_vram | output | 1 | Frame-buffer RAM select |
| sel_stat | output | 1 | Any status register select |
| sel_exp | output | 8 | One-hot expansion slot select |
| dev_offset | output | 24 | Offset inside the selected resource |
| rd_data | output | 32 | Read data for the status registers, lane mask otherwise |
| handled | output | 1 | Access reached a decoded resource |
| unhandled | output | 1 | Registered: previous access reached nothing |
| map_live | output | 1 | 0 = boot overlay in force |

## Verification
On every cycle the assertions check these points:
- Selects are mutually exclusive and stay quiet when idle.
- While the overlay holds, no RAM or zone-A select can appear.
- `unhandled` follows the handled flag of the previous access.
- `map_live` moves only on a write to its control location, and never on an odd byte write.
- Long status reads carry equal halves.

Only the bench scenarios can show the rest:
- The exact address map: slot boundaries, mirroring offsets, the RAM gap and expansion slot numbering.
- Byte-lane selection of the status values.
- The release and re-entry of the overlay, seen through the addresses that later accesses reach.

// File: rtl/boot_map_pkg.sv
`timescale 1ns/1ps
package boot_map_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2
   } acc_size_e;

   typedef enum logic [3:0] {
      RG_NONE,
      RG_ROM,
      RG_RAM,
      RG_MAP,
      RG_VRAM,
      RG_GSTAT,
      RG_BSTAT0,
      RG_BSTAT1,
      RG_EXP,
      RG_OVLCTL
   } region_e;

   // All-ones in the lanes an access of this size occupies
   function automatic logic [31:0] lane_mask(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: lane_mask = 32'h0000_00FF;
         SZ_WORD: lane_mask = 32'h0000_FFFF;
         default: lane_mask = 32'hFFFF_FFFF;
      endcase
   endfunction

   function automatic logic is_status(input region_e r);
      is_status = (r == RG_GSTAT) || (r == RG_BSTAT0) || (r == RG_BSTAT1);
   endfunction

endpackage

// File: rtl/bmd_region.sv
`timescale 1ns/1ps
module bmd_region
   import boot_map_pkg::*;
#(
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned RAM_BYTES = 32'h0020_0000
) (
   input  logic [ADDR_W-1:0] eff_addr,
   output region_e           region
);
   localparam logic [31:0] RAM_LIMIT = 32'(RAM_BYTES);

   logic [31:0] addr_wide;
   assign addr_wide = 32'(eff_addr);

   // Priority: ROM window, RAM size, I/O zone A, I/O zone B
   always_comb begin
      region = RG_NONE;
      if (eff_addr[23:22] == 2'b10) begin
         region = RG_ROM;
      end else if (addr_wide < RAM_LIMIT) begin
         region = RG_RAM;
      end else if (eff_addr[23:22] == 2'b01) begin
         case (eff_addr[19:16])
            4'd0:    region = RG_MAP;
            4'd1:    region = RG_GSTAT;
            4'd2:    region = RG_VRAM;
            4'd3:    region = RG_BSTAT0;
            4'd4:    region = RG_BSTAT1;
            default: region = RG_NONE;
         endcase
      end else if (eff_addr[23:22] == 2'b11) begin
         if (!eff_addr[21])
            region = RG_EXP;
         else if (eff_addr[18:16] == 3'd4 && eff_addr[14:12] == 3'd3)
            region = RG_OVLCTL;
      end
   end
endmodule

// File: rtl/bmd_status_mux.sv
`timescale 1ns/1ps
module bmd_status_mux
   import boot_map_pkg::*;
#(
   parameter int unsigned REG_W  = 16,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  region_e           region,
   input  logic [1:0]        size,
   input  logic              odd_byte,
   input  logic [REG_W-1:0]  gen_val,
   input  logic [REG_W-1:0]  bs0_val,
   input  logic [REG_W-1:0]  bs1_val,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned HALF = REG_W / 2;

   if (DATA_W != 2 * REG_W) begin : g_bad_width
      $error("bmd_status_mux: DATA_W must be twice REG_W");
   end

   logic [REG_W-1:0] picked;
   logic             hit;

   always_comb begin
      hit = rd_req && is_status(region);
      case (region)
         RG_BSTAT0: picked = bs0_val;
         RG_BSTAT1: picked = bs1_val;
         default:   picked = gen_val;
      endcase
   end

   always_comb begin
      rd_data = lane_mask(size);
      if (hit) begin
         case (size)
            SZ_BYTE: rd_data = DATA_W'(odd_byte ? picked[HALF-1:0] : picked[REG_W-1:HALF]);
            SZ_WORD: rd_data = DATA_W'(picked);
            default: rd_data = {picked, picked};
         endcase
      end
   end

   // R6: a long status read mirrors the register into both halves
   a_r6_long_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && is_status(region) && size == SZ_LONG)
         |-> rd_data[DATA_W-1:REG_W] == rd_data[REG_W-1:0]);
endmodule

// File: rtl/bmd_overlay.sv
`timescale 1ns/1ps
module bmd_overlay
   import boot_map_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_wr,
   input  logic [1:0] size,
   input  logic       odd_byte,
   input  logic       wd_hi,
   input  logic       wd_lo,
   output logic       map_live
);
   logic take;
   logic nxt;

   always_comb begin
      take = ctl_wr && !(size == SZ_BYTE && odd_byte);
      nxt  = (size == SZ_BYTE) ? wd_lo : wd_hi;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         map_live <= 1'b0;
      else if (take)
         map_live <= nxt;
   end

   // R8: an odd byte write to the control location leaves the state alone
   a_r8_odd_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && size == SZ_BYTE && odd_byte) |=> $stable(map_live));

   // R8: a word or long write copies data bit 15
   a_r8_word_take: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && size != SZ_BYTE) |=> map_live == $past(wd_hi));
endmodule

// File: rtl/boot_map_decoder.sv
`timescale 1ns/1ps
module boot_map_decoder
   import boot_map_pkg::*;
#(
   parameter int unsigned RAM_BYTES  = 32'h0020_0000,
   parameter int unsigned MAP_BYTES  = 2048,
   parameter int unsigned VRAM_BYTES = 32768,
   parameter int unsigned EXP_SLOTS  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 acc_valid,
   input  logic                 acc_write,
   input  logic [1:0]           acc_size,
   input  logic [23:0]          acc_addr,
   input  logic [31:0]          acc_wdata,
   input  logic [15:0]          gen_status,
   input  logic [15:0]          bus_status0,
   input  logic [15:0]          bus_status1,
   output logic                 sel_rom,
   output logic                 sel_ram,
   output logic                 sel_map,
   output logic                 sel_vram,
   output logic                 sel_stat,
   output logic [EXP_SLOTS-1:0] sel_exp,
   output logic [23:0]          dev_offset,
   output logic [31:0]          rd_data,
   output logic                 handled,
   output logic                 unhandled,
   output logic                 map_live
);
   localparam int unsigned ADDR_W    = 24;
   localparam int unsigned EXP_IDX_W = $clog2(EXP_SLOTS);
   localparam int unsigned EXP_LSB   = 18;
   localparam logic [ADDR_W-1:0] MAP_MASK  = ADDR_W'(MAP_BYTES - 1);
   localparam logic [ADDR_W-1:0] VRAM_MASK = ADDR_W'(VRAM_BYTES - 1);
   localparam logic [ADDR_W-1:0] ROM_MASK  = 24'h3F_FFFF;
   localparam logic [ADDR_W-1:0] EXP_MASK  = ADDR_W'((1 << EXP_LSB) - 1);

   if (RAM_BYTES > 32'h0040_0000) begin : g_bad_ram
      $error("boot_map_decoder: RAM_BYTES must not exceed 4 MiB");
   end
   if (MAP_BYTES == 0 || MAP_BYTES > 65536 || (MAP_BYTES & (MAP_BYTES - 1)) != 0) begin : g_bad_map
      $error("boot_map_decoder: MAP_BYTES must be a power of two up to 64 KiB");
   end
   if (VRAM_BYTES == 0 || VRAM_BYTES > 65536 || (VRAM_BYTES & (VRAM_BYTES - 1)) != 0) begin : g_bad_vram
      $error("boot_map_decoder: VRAM_BYTES must be a power of two up to 64 KiB");
   end
   if (EXP_SLOTS != 8) begin : g_bad_exp
      $error("boot_map_decoder: EXP_SLOTS must be 8 (address bits 20:18)");
   end

   logic [ADDR_W-1:0] eff_addr;
   region_e           region;
   logic              ctl_wr;
   logic              wdata_unused;

   // Boot overlay: force bit 23 until software releases it
   assign eff_addr = map_live ? acc_addr : {1'b1, acc_addr[22:0]};

   bmd_region #(
      .ADDR_W    (ADDR_W),
      .RAM_BYTES (RAM_BYTES)
   ) u_region (
      .eff_addr (eff_addr),
      .region   (region)
   );

   assign ctl_wr = acc_valid && acc_write && (region == RG_OVLCTL);
   assign wdata_unused = ^{acc_wdata[31:16], acc_wdata[14:8], acc_wdata[6:0]};

   bmd_overlay u_overlay (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_wr   (ctl_wr),
      .size     (acc_size),
      .odd_byte (acc_addr[0]),
      .wd_hi    (acc_wdata[15]),
      .wd_lo    (acc_wdata[7]),
      .map_live (map_live)
   );

   bmd_status_mux #(
      .REG_W  (16),
      .DATA_W (32)
   ) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_req   (acc_valid && !acc_write),
      .region   (region),
      .size     (acc_size),
      .odd_byte (eff_addr[0]),
      .gen_val  (gen_status),
      .bs0_val  (bus_status0),
      .bs1_val  (bus_status1),
      .rd_data  (rd_data)
   );

   always_comb begin
      sel_rom  = acc_valid && region == RG_ROM;
      sel_ram  = acc_valid && region == RG_RAM;
      sel_map  = acc_valid && region == RG_MAP;
      sel_vram = acc_valid && region == RG_VRAM;
      sel_stat = acc_valid && is_status(region);
      handled  = acc_valid && region != RG_NONE && !(region == RG_OVLCTL && !acc_write);
   end

   for (genvar s = 0; s < EXP_SLOTS; s++) begin : g_exp
      assign sel_exp[s] = acc_valid && region == RG_EXP &&
                          eff_addr[EXP_LSB +: EXP_IDX_W] == EXP_IDX_W'(s);
   end

   always_comb begin
      case (region)
         RG_ROM:  dev_offset = eff_addr & ROM_MASK;
         RG_MAP:  dev_offset = eff_addr & MAP_MASK;
         RG_VRAM: dev_offset = eff_addr & VRAM_MASK;
         RG_EXP:  dev_offset = eff_addr & EXP_MASK;
         default: dev_offset = eff_addr;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         unhandled <= 1'b0;
      else
         unhandled <= acc_valid && !handled;
   end

   // R4: at most one resource selected
   a_r4_one_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel_rom, sel_ram, sel_map, sel_vram, sel_stat, |sel_exp}));

   // R12: quiet when idle
   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> !(sel_rom || sel_ram || sel_map || sel_vram || sel_stat || |sel_exp || handled));

   // R1: no RAM or zone-A resource is reachable under the overlay
   a_r1_overlay_forces: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !map_live) |-> !(sel_ram || sel_map || sel_vram || sel_stat));

   // R10: the flag follows the previous access
   a_r10_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !handled) |=> unhandled);
   a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_valid || handled) |=> !unhandled);

   // R7: writes elsewhere than the control location leave the overlay alone
   a_r7_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr |=> $stable(map_live));
endmodule

// File: tb/boot_map_decoder_tb.sv
`timescale 1ns/1ps
module boot_map_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [1:0]  acc_size = 2'd0;
   logic [23:0] acc_addr = 24'h0;
   logic [31:0] acc_wdata = 32'h0;
   logic [15:0] gen_status  = 16'h1234;
   logic [15:0] bus_status0 = 16'hBEEF;
   logic [15:0] bus_status1 = 16'hC3A5;
   logic        sel_rom, sel_ram, sel_map, sel_vram, sel_stat;
   logic [7:0]  sel_exp;
   logic [23:0] dev_offset;
   logic [31:0] rd_data;
   logic        handled, unhandled, map_live;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   boot_map_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_size(acc_size), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
      .gen_status(gen_status), .bus_status0(bus_status0), .bus_status1(bus_status1),
      .sel_rom(sel_rom), .sel_ram(sel_ram), .sel_map(sel_map), .sel_vram(sel_vram),
      .sel_stat(sel_stat), .sel_exp(sel_exp), .dev_offset(dev_offset),
      .rd_data(rd_data), .handled(handled), .unhandled(unhandled), .map_live(map_live)
   );

   // code: 0 none, 1 rom, 2 ram, 3 map, 4 vram, 5 status, 8+n slot n, 31 conflict
   // fields: wr, size, addr, wdata, code, offset, rd_data, handled
   localparam int NV = 21;
   localparam logic [120:0] VEC [NV] = '{
      {1'b0, 2'd2, 24'h000010, 32'h0,        5'd2,  24'h000010, 32'hFFFFFFFF, 1'b1},
      {1'b0, 2'd0, 24'h1FFFFF, 32'h0,        5'd2,  24'h1FFFFF, 32'h000000FF, 1'b1},
      {1'b0, 2'd1, 24'h200000, 32'h0,        5'd0,  24'h200000, 32'h0000FFFF, 1'b0},
      {1'b0, 2'd1, 24'h800002, 32'h0,        5'd1,  24'h000002, 32'h0000FFFF, 1'b1},
      {1'b1, 2'd2, 24'hBFFFFC, 32'hDEADBEEF, 5'd1,  24'h3FFFFC, 32'hFFFFFFFF, 1'b1},
      {1'b0, 2'd0, 24'h400805, 32'h0,        5'd3,  24'h000005, 32'h000000FF, 1'b1},
      {1'b0, 2'd1, 24'h4007FE, 32'h0,        5'd3,  24'h0007FE, 32'h0000FFFF, 1'b1},
      {1'b0, 2'd2, 24'h410000, 32'h0,        5'd5,  24'h410000, 32'h12341234, 1'b1},
      {1'b0, 2'd0, 24'h430000, 32'h0,        5'd5,  24'h430000, 32'h000000BE, 1'b1},
      {1'b0, 2'd0, 24'h440001, 32'h0,        5'd5,  24'h440001, 32'h000000A5, 1'b1},
      {1'b0, 2'd1, 24'h440002, 32'h0,        5'd5,  24'h440002, 32'h0000C3A5, 1'b1},
      {1'b0, 2'd2, 24'h42A004, 32'h0,        5'd4,  24'h002004, 32'hFFFFFFFF, 1'b1},
      {1'b1, 2'd1, 24'h430000, 32'h0000FFFF, 5'd5,  24'h430000, 32'h0000FFFF, 1'b1},
      {1'b0, 2'd0, 24'h450000, 32'h0,        5'd0,  24'h450000, 32'h000000FF, 1'b0},
      {1'b0, 2'd2, 24'h4F0000, 32'h0,        5'd0,  24'h4F0000, 32'hFFFFFFFF, 1'b0},
      {1'b0, 2'd1, 24'hC00000, 32'h0,        5'd8,  24'h000000, 32'h0000FFFF, 1'b1},
      {1'b0, 2'd0, 24'hDC0003, 32'h0,        5'd15, 24'h000003, 32'h000000FF, 1'b1},
      {1'b0, 2'd1, 24'hC80000, 32'h0,        5'd10, 24'h000000, 32'h0000FFFF, 1'b1},
      {1'b0, 2'd1, 24'hE43000, 32'h0,        5'd0,  24'hE43000, 32'h0000FFFF, 1'b0},
      {1'b0, 2'd2, 24'hF20000, 32'h0,        5'd0,  24'hF20000, 32'hFFFFFFFF, 1'b0},
      {1'b1, 2'd0, 24'hE43001, 32'h0,        5'd0,  24'hE43001, 32'h000000FF, 1'b1}
   };

   function automatic int obs_code();
      int n = 0;
      int c = 0;
      if (sel_rom)  begin n++; c = 1; end
      if (sel_ram)  begin n++; c = 2; end
      if (sel_map)  begin n++; c = 3; end
      if (sel_vram) begin n++; c = 4; end
      if (sel_stat) begin n++; c = 5; end
      for (int i = 0; i < 8; i++) if (sel_exp[i]) begin n++; c = 8 + i; end
      return (n > 1) ? 31 : c;
   endfunction

   function automatic string tag_of(input int code, input logic wr, input logic h);
      if (code == 1) return wr ? "R2/R7" : "R2";
      if (code == 2) return "R3";
      if (code == 3 || code == 4) return "R5";
      if (code == 5) return wr ? "R7" : "R6";
      if (code >= 8) return "R9";
      if (h) return "R8";
      return "R10";
   endfunction

   task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic access(input logic wr, input logic [1:0] sz, input logic [23:0] a,
                         input logic [31:0] wd, input int code, input logic [23:0] off,
                         input logic [31:0] rd, input logic h, input logic live, input string tag);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = wr; acc_size = sz; acc_addr = a; acc_wdata = wd;
      #1;
      check(tag, "select", 32'(obs_code()), 32'(code));
      check(tag, "offset", 32'(dev_offset), 32'(off));
      check("R11/R6", "rd_data", rd_data, rd);
      check(tag, "handled", 32'(handled), 32'(h));
      @(posedge clk);
      #1;
      acc_valid = 1'b0;
      check("R10", "unhandled", 32'(unhandled), 32'(!h));
      check(tag, "map_live", 32'(map_live), 32'(live));
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1, R12: reset state and quiet outputs
      check("R1", "reset map_live", 32'(map_live), 32'd0);
      check("R10", "reset unhandled", 32'(unhandled), 32'd0);
      check("R12", "reset selects", 32'(obs_code()), 32'd0);
      rst_n = 1'b1;
      // R1: overlay forces ROM and shifts zone A into expansion space
      access(1'b0, 2'd2, 24'h000100, 32'h0, 1, 24'h000100, 32'hFFFFFFFF, 1'b1, 1'b0, "R1");
      access(1'b0, 2'd1, 24'h410000, 32'h0, 8, 24'h010000, 32'h0000FFFF, 1'b1, 1'b0, "R1");
      // R8: odd byte write ignored, even byte releases via bit 7
      access(1'b1, 2'd0, 24'hE43001, 32'h000000FF, 0, 24'hE43001, 32'h000000FF, 1'b1, 1'b0, "R8");
      access(1'b1, 2'd0, 24'hE43000, 32'h00000080, 0, 24'hE43000, 32'h000000FF, 1'b1, 1'b1, "R8");
      // table walk with the overlay released
      for (int i = 0; i < NV; i++) begin
         logic [120:0] v;
         v = VEC[i];
         access(v[120], v[119:118], v[117:94], v[93:62], int'(v[61:57]), v[56:33], v[32:1], v[0],
                1'b1, tag_of(int'(v[61:57]), v[120], v[0]));
      end
      // R8: word write with bit 15 low re-enters the overlay
      access(1'b1, 2'd1, 24'hF43000, 32'h00007FFF, 0, 24'hF43000, 32'h0000FFFF, 1'b1, 1'b0, "R8");
      access(1'b0, 2'd1, 24'h000100, 32'h0, 1, 24'h000100, 32'h0000FFFF, 1'b1, 1'b0, "R1");
      // R8: long write takes bit 15
      access(1'b1, 2'd2, 24'hE43FFC, 32'h00008000, 0, 24'hE43FFC, 32'hFFFFFFFF, 1'b1, 1'b1, "R8");
      access(1'b0, 2'd1, 24'h000100, 32'h0, 2, 24'h000100, 32'h0000FFFF, 1'b1, 1'b1, "R3");
      // R7: ROM write does not move the overlay state
      access(1'b1, 2'd1, 24'h800000, 32'h00000000, 1, 24'h000000, 32'h0000FFFF, 1'b1, 1'b1, "R7");
      // R10: back-to-back unhandled accesses each flag
      access(1'b0, 2'd0, 24'h3FFFFF, 32'h0, 0, 24'h3FFFFF, 32'h000000FF, 1'b0, 1'b1, "R10");
      access(1'b0, 2'd0, 24'h460000, 32'h0, 0, 24'h460000, 32'h000000FF, 1'b0, 1'b1, "R4");
      // R12: idle cycle
      @(negedge clk);
      acc_valid = 1'b0; acc_addr = 24'h800000;
      #1;
      check("R12", "idle selects", 32'(obs_code()), 32'd0);
      check("R12", "idle handled", 32'(handled), 32'd0);
      @(posedge clk);
      #1;
      check("R10", "idle unhandled", 32'(unhandled), 32'd0);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule